// File: doc/BRIEF.md
# Gated Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame. A character enters through a valid/ready port into a one-entry holding register. From there it moves into a shift register, which sends a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one, one and a half or two high stop bits. Every bit lasts a programmable number of falling edges of a free-running transmit clock, `txclk_i`. That clock is sampled in the system clock domain, and the serial line only changes in the system cycle that follows a detected falling edge.

A new frame may begin only while the enable command is set and the active-low clear-to-send input is low. If either gate closes while a frame is in progress, that frame still finishes, and a character in the holding register waits for the gates to open again. The holding register makes back-to-back transmission possible. While one frame is being shifted, the next character can be written. It then starts in the edge where the previous frame's last stop bit ends, with no idle gap. A break command forces the line low. The frame settings are captured when each frame starts.

Back-pressure rule: a character is accepted in a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high exactly when the holding register is empty and the enable command is set. It does not depend on `in_valid_i`, and a source may hold `in_valid_i` and `in_data_i` steady for any number of cycles.

Top module: `txline_tx`

## Requirements
- R1: After reset, `txd_o` is high, `tx_empty_o` is high, and `in_ready_o` is low while `tx_en_i` is low.
- R2: `in_ready_o` is high exactly when the holding register is empty and `tx_en_i` is high. After a character is accepted, `in_ready_o` stays low until that character has moved into the shift register.
- R3: A frame starts only on a transmit-clock falling edge where `tx_en_i` is high and `cts_ni` is low. A held character waits, with the line high, as long as either condition fails.
- R4: A frame is one low start bit followed by the data bits, least significant bit first. The number of data bits is 5, 6, 7 or 8 for `cfg_width_i` = 0, 1, 2 or 3.
- R5: When `cfg_par_en_i` is 1, a parity bit follows the data. Its value is the XOR of the sent data bits when `cfg_par_odd_i` is 0, so that the count of ones is even, and the inverse of that XOR when `cfg_par_odd_i` is 1.
- R6: The stop time, in bit periods, is 1, 1.5, 2 and 2 for `cfg_stop_i` = 0, 1, 2 and 3. It is counted in transmit-clock falling edges, as ceil(factor × halves / 2), so 1.5 stop bits at factor 1 lasts 2 edges.
- R7: Each start, data and parity bit lasts `factor` transmit-clock falling edges. The factor is 1, 16 and 64 for `cfg_rate_i` = 0, 1 and 2 or 3. The whole frame therefore lasts factor × (1 + data bits + parity) plus the stop time, in edges.
- R8: When `cts_ni` goes high or `tx_en_i` goes low during a frame, that frame is still sent completely and correctly.
- R9: `tx_empty_o` is high exactly when no frame is in progress and the holding register is empty.
- R10: While `brk_i` is high, `txd_o` is low. When it is released, the line returns to the level the transmitter would otherwise drive.
- R11: A character that is waiting when a frame's stop time ends starts in that same edge, so its start bit directly follows the last stop bit.
- R12: The width, parity, stop and rate settings are captured at the start of a frame. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txclk_i | input | 1 | Transmit bit clock; bit timing advances on its falling edges |
| tx_en_i | input | 1 | Enable command for starting new frames |
| cts_ni | input | 1 | Active-low clear-to-send |
| brk_i | input | 1 | Break command; forces the line low |
| cfg_width_i | input | 2 | Data width code (5 + code bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop_i | input | 2 | Stop length code |
| cfg_rate_i | input | 2 | Baud factor code |
| in_valid_i | input | 1 | Character offered |
| in_data_i | input | 8 | Character; unused upper bits ignored |
| in_ready_o | output | 1 | Holding register empty and enabled |
| txd_o | output | 1 | Serial line, idles high |
| tx_empty_o | output | 1 | No frame in progress and nothing held |

## Verification
The hardest situation to reach from the ports is a zero-gap hand-over. A second character has to be written exactly while the first is being shifted, and the gap between the two start bits must then be measured to the system cycle. The bench does this with two parallel threads. One writes both characters as soon as `in_ready_o` allows. The other captures both frames and compares the cycle distance between their start edges with the computed frame length. Disable, clear-to-send and configuration changes are injected the same way, from a second thread, while a capture thread is in the middle of a frame.

// File: rtl/txline_pkg.sv
package txline_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } txline_state_e;

  typedef struct packed {
    logic [1:0] width;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
    logic [1:0] rate;
  } txline_cfg_t;

  // stop length in half-bit units
  function automatic logic [2:0] stop_halves(input logic [1:0] code);
    case (code)
      2'd0:    stop_halves = 3'd2;
      2'd1:    stop_halves = 3'd3;
      default: stop_halves = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/txline_edge.sv
module txline_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= async_i;
  end

  for (genvar g = 1; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC-1];
  end

  assign fall_o = last_q & ~sync_q[SYNC-1];
endmodule

// File: rtl/txline_hold.sv
module txline_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (take_i) full_o <= 1'b0;
      if (wr_i) begin
        full_o <= 1'b1;
        data_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/txline_framer.sv
module txline_framer
  import txline_pkg::*;
#(
  parameter int DW      = 8,
  parameter int FAC_MID = 16,
  parameter int FAC_HI  = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          load_ok_i,
  input  logic [DW-1:0] load_data_i,
  input  txline_cfg_t   cfg_i,
  output logic          take_o,
  output logic          line_o,
  output txline_state_e state_o
);
  localparam int CNTW = $clog2(FAC_HI * 2) + 1;
  localparam int IW   = $clog2(DW);
  localparam int MINW = DW - 3;

  txline_state_e   state_q;
  txline_cfg_t     cfg_q;
  logic [CNTW-1:0] cnt_q;
  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   sh_q;
  logic            par_q;

  logic [CNTW-1:0] fac;
  logic [CNTW+2:0] stop_prod;
  logic [CNTW-1:0] stop_len;
  logic [IW-1:0]   last_idx;
  logic            bit_end, stop_end;
  logic [DW-1:0]   masked;
  logic            par_new;

  always_comb begin
    case (cfg_q.rate)
      2'd0:    fac = CNTW'(1);
      2'd1:    fac = CNTW'(FAC_MID);
      default: fac = CNTW'(FAC_HI);
    endcase
  end

  assign stop_prod = ({3'b000, fac} * {{CNTW{1'b0}}, stop_halves(cfg_q.stop)}) + (CNTW+3)'(1);
  assign stop_len  = CNTW'(stop_prod >> 1);
  assign last_idx  = IW'(cfg_q.width) + IW'(MINW - 1);
  assign bit_end   = (cnt_q == fac - CNTW'(1));
  assign stop_end  = (cnt_q == stop_len - CNTW'(1));

  // parity over the bits that the incoming setting will send
  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign masked[g] = load_data_i[g] & (g < (int'(cfg_i.width) + MINW));
  end
  assign par_new = (^masked) ^ cfg_i.par_odd;

  assign take_o = fall_i & load_ok_i &
                  ((state_q == ST_IDLE) | ((state_q == ST_STOP) & stop_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else if (fall_i) begin
      case (state_q)
        ST_START: begin
          if (bit_end) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= sh_q >> 1;
            if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else                   idx_q   <= idx_q + IW'(1);
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        ST_PAR: begin
          if (bit_end) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        ST_STOP: begin
          if (stop_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
      if (take_o) begin
        state_q <= ST_START;
        cnt_q   <= '0;
        sh_q    <= load_data_i;
        cfg_q   <= cfg_i;
        par_q   <= par_new;
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/txline_tx.sv
module txline_tx
  import txline_pkg::*;
#(
  parameter int DW      = 8,
  parameter int FAC_MID = 16,
  parameter int FAC_HI  = 64,
  parameter int SYNC    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txclk_i,
  input  logic          tx_en_i,
  input  logic          cts_ni,
  input  logic          brk_i,
  input  logic [1:0]    cfg_width_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic [1:0]    cfg_stop_i,
  input  logic [1:0]    cfg_rate_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          txd_o,
  output logic          tx_empty_o
);
  logic          fall, take, hold_full, line;
  logic [DW-1:0] hold_data;
  txline_state_e fr_state;
  txline_cfg_t   cfg;

  assign cfg = '{width: cfg_width_i, par_en: cfg_par_en_i, par_odd: cfg_par_odd_i,
                 stop: cfg_stop_i, rate: cfg_rate_i};

  txline_edge #(.SYNC(SYNC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(txclk_i), .fall_o(fall)
  );

  txline_hold #(.DW(DW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(in_valid_i & in_ready_o), .wr_data_i(in_data_i),
    .take_i(take), .full_o(hold_full), .data_o(hold_data)
  );

  txline_framer #(.DW(DW), .FAC_MID(FAC_MID), .FAC_HI(FAC_HI)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall),
    .load_ok_i(hold_full & tx_en_i & ~cts_ni), .load_data_i(hold_data),
    .cfg_i(cfg), .take_o(take), .line_o(line), .state_o(fr_state)
  );

  assign in_ready_o = ~hold_full & tx_en_i;
  assign tx_empty_o = (fr_state == ST_IDLE) & ~hold_full;
  assign txd_o      = line & ~brk_i;
endmodule

// File: rtl/txline_tx_chk.sv
module txline_tx_chk
  import txline_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          cts_ni,
  input logic          brk_i,
  input logic          in_ready_o,
  input logic          txd_o,
  input logic          tx_empty_o,
  input logic          hold_full,
  input logic          take,
  input logic [DW-1:0] hold_data,
  input txline_state_e fr_state
);
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_full |-> !in_ready_o);

  a_r2_ready_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> tx_en_i);

  a_r2_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));

  a_r3_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_state == ST_START && $past(fr_state) != ST_START) |-> $past(tx_en_i && !cts_ni));

  a_r8_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_state == ST_START || fr_state == ST_DATA || fr_state == ST_PAR)
      |=> fr_state != ST_IDLE);

  a_r9_empty_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o);

  a_r10_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);
endmodule

bind txline_tx txline_tx_chk #(.DW(DW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .cts_ni(cts_ni), .brk_i(brk_i),
  .in_ready_o(in_ready_o), .txd_o(txd_o), .tx_empty_o(tx_empty_o),
  .hold_full(hold_full), .take(take), .hold_data(hold_data), .fr_state(fr_state)
);

// File: tb/txline_tx_tb_top.sv
`timescale 1ns/1ps
module txline_tx_tb_top;
  localparam int TXP = 4; // system cycles per transmit clock period

  logic clk = 1'b0, rst_n = 1'b0, txclk = 1'b1;
  logic tx_en = 1'b0, cts_n = 1'b0, brk = 1'b0;
  logic [1:0] c_width = 2'd3, c_stop = 2'd0, c_rate = 2'd0;
  logic c_pe = 1'b0, c_po = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, txd, tx_empty;
  int   n_checks = 0, n_fail = 0;
  int   cyc = 0, txc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    txc = (txc + 1) % (TXP / 2);
    if (txc == 0) txclk = ~txclk;
  end

  txline_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .txclk_i(txclk), .tx_en_i(tx_en), .cts_ni(cts_n),
    .brk_i(brk), .cfg_width_i(c_width), .cfg_par_en_i(c_pe), .cfg_par_odd_i(c_po),
    .cfg_stop_i(c_stop), .cfg_rate_i(c_rate), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .txd_o(txd), .tx_empty_o(tx_empty)
  );

  // {data, width, par_en, par_odd, stop, rate}
  localparam logic [15:0] VEC [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0},
    {8'h3C, 2'd0, 1'b1, 1'b0, 2'd1, 2'd0},
    {8'hF0, 2'd2, 1'b1, 1'b1, 2'd2, 2'd1},
    {8'h5A, 2'd1, 1'b0, 1'b0, 2'd1, 2'd1},
    {8'h81, 2'd3, 1'b1, 1'b1, 2'd0, 2'd2},
    {8'hFF, 2'd3, 1'b1, 1'b0, 2'd3, 2'd0},
    {8'h00, 2'd3, 1'b1, 1'b1, 2'd1, 2'd1},
    {8'h6D, 2'd2, 1'b0, 1'b0, 2'd0, 2'd3}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int fac_of(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64;
  endfunction

  function automatic int halves_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 3 : 4;
  endfunction

  // expected bits: start, data LSB first, parity, first stop bit
  function automatic logic [11:0] exp_bits(input logic [7:0] d, input int nb,
                                          input logic pe, input logic po);
    logic [11:0] v = '0;
    logic p = po;
    for (int i = 0; i < nb; i++) begin
      v[1+i] = d[i];
      p ^= d[i];
    end
    if (pe) v[1+nb] = p;
    v[1+nb+int'(pe)] = 1'b1;
    return v;
  endfunction

  task automatic send(input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // waits for a start edge, samples each bit mid-way
  task automatic capture(input int nb, input logic pe, input int fac,
                         output logic [11:0] got, output int t0);
    int guard = 0;
    got = '0;
    while (txd !== 1'b0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    t0 = cyc;
    repeat (fac * TXP / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb + int'(pe) + 2; i++) begin
      repeat (fac * TXP) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic wait_empty(output int t);
    int guard = 0;
    while (tx_empty !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [11:0] got, exp;
    int t0, t1, t2, len;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 idle line", txd, 1);
    check(tx_empty === 1'b1, "R1 empty", tx_empty, 1);
    check(in_ready === 1'b0, "R1 ready low while disabled", in_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(in_ready === 1'b0, "R2 ready needs enable", in_ready, 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R2 ready when empty and enabled", in_ready, 1);

    // table walk: R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v = VEC[k];
      int nb = int'(v[7:6]) + 5;
      int fac = fac_of(v[1:0]);
      c_width = v[7:6]; c_pe = v[5]; c_po = v[4]; c_stop = v[3:2]; c_rate = v[1:0];
      fork
        send(v[15:8]);
        capture(nb, v[5], fac, got, t0);
      join
      exp = exp_bits(v[15:8], nb, v[5], v[4]);
      check(got === exp, "R4 R5 frame bits", got, exp);
      wait_empty(t1);
      len = TXP * (fac * (1 + nb + int'(v[5])) + (fac * halves_of(v[3:2]) + 1) / 2);
      check((t1 - t0) == len, "R6 R7 frame length", t1 - t0, len);
    end

    c_width = 2'd3; c_pe = 1'b0; c_po = 1'b0; c_stop = 2'd0; c_rate = 2'd0;

    // R3 clear-to-send blocks a start
    cts_n = 1'b1;
    send(8'h96);
    check(in_ready === 1'b0, "R2 ready low while held", in_ready, 0);
    repeat (40) @(negedge clk);
    check(txd === 1'b1, "R3 no start while cts high", txd, 1);
    check(tx_empty === 1'b0, "R9 not empty while held", tx_empty, 0);
    cts_n = 1'b0;
    capture(8, 1'b0, 1, got, t0);
    exp = exp_bits(8'h96, 8, 1'b0, 1'b0);
    check(got === exp, "R3 held char sent after cts", got, exp);
    wait_empty(t1);
    check(tx_empty === 1'b1, "R9 empty after frame", tx_empty, 1);

    // R8 cts rises mid-frame
    c_rate = 2'd1;
    fork
      send(8'hC3);
      capture(8, 1'b0, 16, got, t0);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (3 * 16 * TXP) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    exp = exp_bits(8'hC3, 8, 1'b0, 1'b0);
    check(got === exp, "R8 frame completes after cts high", got, exp);
    wait_empty(t1);
    check(tx_empty === 1'b1, "R8 returns idle", tx_empty, 1);
    cts_n = 1'b0;

    // R8 enable drops mid-frame, and R12 settings change mid-frame
    fork
      send(8'h4B);
      capture(8, 1'b0, 16, got, t0);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (2 * 16 * TXP) @(negedge clk);
        tx_en = 1'b0;
        c_width = 2'd0; c_pe = 1'b1; c_rate = 2'd0;
      end
    join
    exp = exp_bits(8'h4B, 8, 1'b0, 1'b0);
    check(got === exp, "R8 R12 frame unchanged", got, exp);
    wait_empty(t1);
    check((t1 - t0) == TXP * 16 * 10, "R12 length kept", t1 - t0, TXP * 160);
    tx_en = 1'b1;
    c_width = 2'd3; c_pe = 1'b0; c_rate = 2'd0;
    @(negedge clk);

    // R11 back-to-back with no gap, R2 ready during shifting
    fork
      begin
        send(8'h11);
        while (!in_ready) @(negedge clk);
        check(txd === 1'b0 || tx_empty === 1'b0, "R2 ready while shifting", in_ready, 1);
        send(8'hE7);
        check(in_ready === 1'b0, "R2 ready low after second write", in_ready, 0);
      end
      begin
        capture(8, 1'b0, 1, got, t0);
        exp = exp_bits(8'h11, 8, 1'b0, 1'b0);
        check(got === exp, "R11 first frame", got, exp);
        capture(8, 1'b0, 1, got, t2);
        exp = exp_bits(8'hE7, 8, 1'b0, 1'b0);
        check(got === exp, "R11 second frame", got, exp);
      end
    join
    check((t2 - t0) == TXP * 10, "R11 no idle gap", t2 - t0, TXP * 10);
    wait_empty(t1);

    // R10 break
    brk = 1'b1;
    repeat (3) @(negedge clk);
    check(txd === 1'b0, "R10 break forces low", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R10 release restores idle", txd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule